// File: doc/BRIEF.md
# Three-Group Clock Divider with Selectable Group A Phase

This block takes one fast source clock and produces three groups of clock outputs. Group C runs at half the source rate, group B at a quarter and group A at an eighth. All three come from one free-running counter, so their edges stay aligned to each other. Every output is a registered logic level with a 50% duty cycle. Each output within a group is a copy of the same signal: group A has five copies, group B four and group C two.

The group A outputs can be moved against groups B and C by a whole number of source-clock periods. A 2-bit select picks the shift, and a new select takes effect only at a counter wrap. A test input picks the source clock. When it is low the oscillator clock drives the divider. When it is high the reference clock drives it directly. The source selection is treated as static and is changed only while reset is held.

Top module: `clkdiv_phase`

## Requirements
- R1: While `rst_n` is low at a rising source edge, every output is 0 after that edge. The reset is synchronous and active low.
- R2: Group C toggles on every source edge, which gives source/2 with a 50% duty cycle. It first rises on the first edge at which `rst_n` is high.
- R3: Group B toggles on exactly those edges where group C falls, which gives source/4 with a 50% duty cycle. It first rises on the second edge after reset is released.
- R4: With `phase_sel` = 2'b10, group A is source/8 with a 50% duty cycle. It is high on edges 4 to 7 of every 8-edge frame, where the first edge after reset is edge 1.
- R5: With `phase_sel` = 2'b00, every group A edge comes one source period later than under 2'b10.
- R6: With `phase_sel` = 2'b01, group A edges come one source period earlier than under 2'b10. With 2'b11 they come two periods earlier.
- R7: The select sampled at the edge where the count goes from 7 to 0 governs group A from the next edge on. The select held during reset governs from the first edge after release. A select change at any other time leaves group A unchanged until that wrap.
- R8: The five group A outputs always carry one value, the four group B outputs carry one value, and the two group C outputs carry one value.
- R9: With `test_sel` = 0 the divider runs on `osc_clk`. With `test_sel` = 1 it runs on `ref_clk`, and R2 to R7 then hold with respect to `ref_clk` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast oscillator clock (normal source) |
| ref_clk | input | 1 | Reference clock (source in test mode) |
| test_sel | input | 1 | 1 selects `ref_clk` as the source; static outside reset |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the selected source |
| phase_sel | input | 2 | Group A shift code: 00 = +1, 10 = 0, 01 = -1, 11 = -2 source periods |
| grp_a | output | 5 | Group A copies, source/8, shifted |
| grp_b | output | 4 | Group B copies, source/4 |
| grp_c | output | 2 | Group C copies, source/2 |

## Verification
The bench builds the block with its default parameters: a 3-bit counter and output copy counts of 5, 4 and 2. The counter therefore wraps every eight source edges, so each of the four shift codes, and the deferral of a select change until the next wrap, is seen many times in a short run. It also means every copy of every group is checked on every edge. Running in test mode on a reference clock with a different period shows that the divider follows the selected source and not the oscillator.

// File: rtl/clkdiv_pkg.sv
// Package: shared encodings for the three-group clock divider.
// Assumes the group A shift select is a 2-bit code whose values are fixed
// by the pin encoding below.
package clkdiv_pkg;

    // Group A shift codes; the bit patterns are fixed by the input encoding.
    typedef enum logic [1:0] {
        SH_LATE1  = 2'b00,   // group A one source period later
        SH_NONE   = 2'b10,   // no shift
        SH_EARLY1 = 2'b01,   // one source period earlier
        SH_EARLY2 = 2'b11    // two source periods earlier
    } shift_e;

    // Signed delay in source periods that a shift code applies to group A.
    function automatic int shift_delay(input shift_e code);
        case (code)
            SH_LATE1:  return 1;
            SH_NONE:   return 0;
            SH_EARLY1: return -1;
            default:   return -2;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_src_mux.sv
// Module: clkdiv_src_mux
// Picks the clock that drives the divider: the oscillator in normal
// operation or the reference clock in test mode.
// Assumes sel is static outside reset, so no glitch-free switching is built.
module clkdiv_src_mux (
    input  logic osc_clk,
    input  logic ref_clk,
    input  logic sel,
    output logic src_clk
);

    // Plain two-way clock select.
    always_comb begin
        src_clk = sel ? ref_clk : osc_clk;
    end

endmodule

// File: rtl/clkdiv_counter.sv
// Module: clkdiv_counter
// Free-running phase counter that every output group is derived from.
// Assumes a synchronous active-low reset on the selected source clock.
// Gives the incremented count (the value after this edge) and a wrap flag
// that is high while the count holds its maximum.
module clkdiv_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Next count value and wrap detection.
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        wrap    = (cnt_q == CNT_MAX);
    end

    // Advance the count each source edge; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/clkdiv_shift_hold.sv
// Module: clkdiv_shift_hold
// Holds the group A shift code that is in force. It loads the input during
// reset and at a counter wrap only, so group A never sees a select change
// in the middle of a frame.
// Assumes wrap comes from the shared counter on the same clock.
module clkdiv_shift_hold
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_in,
    input  logic       wrap,
    output shift_e     sel_eff
);

    // Load the select in reset or at a wrap; keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) begin
            sel_eff <= shift_e'(sel_in);
        end
    end

    // The code in force changes only across a wrap edge.
    assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wrap)) |-> $stable(sel_eff));

endmodule

// File: rtl/clkdiv_group_regs.sv
// Module: clkdiv_group_regs
// Registers the three group levels from the next count value and fans each
// level out to its copies. Group A reads the count offset by the code in
// force, modulo the counter range.
// Assumes CNT_W >= 3: C uses bit CNT_W-3, B bit CNT_W-2, A bit CNT_W-1.
module clkdiv_group_regs
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int A_N   = 5,
    parameter int B_N   = 4,
    parameter int C_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_inc,
    input  shift_e           sel_eff,
    output logic [A_N-1:0]   grp_a,
    output logic [B_N-1:0]   grp_b,
    output logic [C_N-1:0]   grp_c
);

    localparam int A_BIT = CNT_W - 1;
    localparam int B_BIT = CNT_W - 2;
    localparam int C_BIT = CNT_W - 3;

    logic [CNT_W-1:0] delay_v;
    logic [CNT_W-1:0] a_idx;
    logic             a_q, b_q, c_q;

    // Offset count for group A: subtract the delay modulo 2**CNT_W.
    always_comb begin
        delay_v = CNT_W'(shift_delay(sel_eff));
        a_idx   = cnt_inc - delay_v;
    end

    // Register the group levels; all are forced low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
            c_q <= 1'b0;
        end else begin
            a_q <= a_idx[A_BIT];
            b_q <= cnt_inc[B_BIT];
            c_q <= cnt_inc[C_BIT];
        end
    end

    // Fan each group level out to its copies.
    for (genvar i = 0; i < A_N; i++) begin : g_a_copy
        assign grp_a[i] = a_q;
    end
    for (genvar i = 0; i < B_N; i++) begin : g_b_copy
        assign grp_b[i] = b_q;
    end
    for (genvar i = 0; i < C_N; i++) begin : g_c_copy
        assign grp_c[i] = c_q;
    end

    // Reset forces every group low by the following edge.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> ({a_q, b_q, c_q} == 3'b000));

    // Group C toggles on every running edge.
    assert_c_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (c_q != $past(c_q)));

    // Group B changes exactly when group C falls.
    assert_b_on_c_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((b_q != $past(b_q)) == $fell(c_q)));

endmodule

// File: rtl/clkdiv_phase.sv
// Module: clkdiv_phase (top)
// Three-group clock divider (/8 shifted, /4, /2) built around one shared
// counter, with a source select for test mode.
// Assumes test_sel changes only while rst_n is held low.
module clkdiv_phase
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int A_N   = 5,
    parameter int B_N   = 4,
    parameter int C_N   = 2
) (
    input  logic           osc_clk,
    input  logic           ref_clk,
    input  logic           test_sel,
    input  logic           rst_n,
    input  logic [1:0]     phase_sel,
    output logic [A_N-1:0] grp_a,
    output logic [B_N-1:0] grp_b,
    output logic [C_N-1:0] grp_c
);

    logic             src_clk;
    logic [CNT_W-1:0] cnt_inc;
    logic             wrap;
    shift_e           sel_eff;

    clkdiv_src_mux u_mux (
        .osc_clk (osc_clk),
        .ref_clk (ref_clk),
        .sel     (test_sel),
        .src_clk (src_clk)
    );

    clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (src_clk),
        .rst_n   (rst_n),
        .cnt_inc (cnt_inc),
        .wrap    (wrap)
    );

    clkdiv_shift_hold u_hold (
        .clk     (src_clk),
        .rst_n   (rst_n),
        .sel_in  (phase_sel),
        .wrap    (wrap),
        .sel_eff (sel_eff)
    );

    clkdiv_group_regs #(
        .CNT_W (CNT_W),
        .A_N   (A_N),
        .B_N   (B_N),
        .C_N   (C_N)
    ) u_regs (
        .clk     (src_clk),
        .rst_n   (rst_n),
        .cnt_inc (cnt_inc),
        .sel_eff (sel_eff),
        .grp_a   (grp_a),
        .grp_b   (grp_b),
        .grp_c   (grp_c)
    );

    // Copies of each group agree at every edge.
    assert_copies_agree_R8: assert property (@(posedge src_clk)
        (grp_a == '0 || grp_a == '1) && (grp_b == '0 || grp_b == '1) &&
        (grp_c == '0 || grp_c == '1));

endmodule

// File: tb/clkdiv_phase_tb.sv
// Scoreboard bench: a model process pushes the expected group levels on
// every source edge, and a monitor pops and compares them at the falling edge.
module clkdiv_phase_tb;

    logic       osc_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       test_sel = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_sel = 2'b10;
    logic [4:0] grp_a;
    logic [3:0] grp_b;
    logic [1:0] grp_c;
    logic       src_clk_tb;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    logic [2:0] sb_q[$];

    // Model state.
    int         m_cnt = 0;
    logic [1:0] m_sel = 2'b10;

    clkdiv_phase u_dut (
        .osc_clk   (osc_clk),
        .ref_clk   (ref_clk),
        .test_sel  (test_sel),
        .rst_n     (rst_n),
        .phase_sel (phase_sel),
        .grp_a     (grp_a),
        .grp_b     (grp_b),
        .grp_c     (grp_c)
    );

    always #5 osc_clk = ~osc_clk;   // 100 MHz
    always #8 ref_clk = ~ref_clk;
    assign src_clk_tb = test_sel ? ref_clk : osc_clk;

    // Offset added to the count for group A, from the R5/R6 shift table.
    function automatic int a_offset(input logic [1:0] s);
        case (s)
            2'b00:   return 7;   // one period later
            2'b10:   return 0;
            2'b01:   return 1;   // one period earlier
            default: return 2;   // two periods earlier
        endcase
    endfunction

    // Driver side of the scoreboard: expected {A,B,C} after each edge.
    always @(posedge src_clk_tb) begin
        int nxt;
        logic [2:0] e;
        if (!rst_n) begin
            m_cnt = 0;
            m_sel = phase_sel;
            e = 3'b000;
        end else begin
            nxt = (m_cnt + 1) % 8;
            e[2] = (((nxt + a_offset(m_sel)) % 8) >= 4);
            e[1] = nxt[1];
            e[0] = nxt[0];
            if (m_cnt == 7) m_sel = phase_sel;
            m_cnt = nxt;
        end
        sb_q.push_back(e);
    end

    // Monitor: compare all copies against the expected levels.
    always @(negedge src_clk_tb) begin
        logic [2:0] e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (grp_a !== {5{e[2]}} || grp_b !== {4{e[1]}} || grp_c !== {2{e[0]}}) begin
                failures++;
                $display("FAIL %s: a=%b b=%b c=%b expected a=%b b=%b c=%b",
                         cur_req, grp_a, grp_b, grp_c, {5{e[2]}}, {4{e[1]}}, {2{e[0]}});
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge src_clk_tb);
        #1;
    endtask

    task automatic check_val(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: outputs held low in reset.
        cur_req = "R1";
        run(4);
        check_val("R1", {grp_a, grp_b, grp_c}, 11'd0);

        // R2 R3 R4 R8: no-shift running, then explicit first-edge checks.
        cur_req = "R2/R3/R4/R8";
        rst_n = 1'b1;
        run(1);
        check_val("R2", {grp_a, grp_b, grp_c}, 11'b00000_0000_11);
        run(1);
        check_val("R3", {grp_a, grp_b, grp_c}, 11'b00000_1111_00);
        run(2);
        check_val("R4", {grp_a, grp_b, grp_c}, 11'b11111_0000_00);
        run(20);

        // R5 with R7: select changed mid-frame, applied at the next wrap.
        cur_req = "R5/R7";
        run(3);
        phase_sel = 2'b00;
        run(24);

        // R6 with R7: both early shifts.
        cur_req = "R6/R7";
        phase_sel = 2'b01;
        run(24);
        phase_sel = 2'b11;
        run(24);

        // R7: select held in reset applies from the first edge.
        cur_req = "R7/R1";
        rst_n = 1'b0;
        phase_sel = 2'b11;
        run(3);
        check_val("R1", {grp_a, grp_b, grp_c}, 11'd0);
        rst_n = 1'b1;
        run(2);
        // -2 shift: A already high two edges after release.
        check_val("R7", {grp_a, grp_b, grp_c}, 11'b11111_1111_00);
        run(14);

        // R9: test mode runs on the reference clock.
        cur_req = "R9/R1";
        rst_n = 1'b0;
        run(2);
        test_sel = 1'b1;
        phase_sel = 2'b10;
        run(3);
        cur_req = "R9/R2/R3/R4";
        rst_n = 1'b1;
        run(20);
        cur_req = "R9/R5";
        phase_sel = 2'b00;
        run(20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule